// File: doc/BRIEF.md
# Indirect-Address Byte-Wide Register Port

This block is a slave port for an 8-bit parallel host bus of the separate-strobe kind: one line picks between address and data, and there are an active-low chip select, an active-low write strobe and an active-low read strobe. The host first sets a 19-bit register pointer. It does this with three write cycles while the select line is low. It then moves 16-bit register contents as two byte cycles while the select line is high, with the low byte first. The port turns these byte cycles into single 16-bit accesses on a plain internal register-bank interface. That interface has an address, write data, a one-cycle write enable, and read data that the bank returns combinationally for the current address.

Every bus strobe is brought into the system clock domain through a two-stage synchroniser. The data and select lines follow the same pipeline. A falling-activity detector marks the end of each cycle with a one-cycle pulse. The write cycle is active while both chip select and the write strobe are low, so it ends on whichever of the two rises first. The address pointer is filled by a byte-lane counter. A two-state data phase machine decides what each data byte means. In state DATA_LO the next byte is the low half. In state DATA_HI it is the high half. It has four transitions:
- LO_WRITE goes DATA_LO to DATA_HI and stores the low byte.
- LO_READ goes DATA_LO to DATA_HI and latches all 16 read bits.
- HI_DONE goes DATA_HI to DATA_LO and completes a write or a read.
- ADDR_CLEAR goes from either state to DATA_LO on any address byte.

Top module: `idx_reg_port`

## Requirements
- R1: Three address-phase write bytes fill the pointer in the order bits [7:0], then [15:8], then [18:16]. Only bits [2:0] of the third byte are used.
- R2: The address byte counter wraps after the third byte, so a fourth address byte overwrites pointer bits [7:0].
- R3: A data-phase write of a low byte followed by a high byte issues exactly one internal write: a one-cycle `reg_we` with `reg_wdata` = {high, low} at the current pointer. The low byte alone issues no write.
- R4: Any address byte returns the data phase to the low byte. A data byte that follows it is treated as a low byte, even if a low byte was pending.
- R5: A read strobe while the select line is low is inhibited. It does not drive the bus and changes neither the pointer nor the data phase.
- R6: `bus_doe` is high only while chip select and the read strobe are both low and the select line is high. A low-byte read presents `reg_rdata[7:0]`.
- R7: The high-byte read presents bits [15:8] of the word latched at the end of the low-byte read, even if `reg_rdata` has changed since then.
- R8: Write data is taken at the end of the cycle, whether the write strobe or chip select rises first.
- R9: Chip select going high between cycles does not reset the byte counter or the data phase. A write strobe while chip select is high is ignored.
- R10: After reset the pointer is zero, `reg_we` is low, the bus is not driven and the data phase is DATA_LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Address/data select: 0 address byte, 1 data byte |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_din | input | 8 | Byte from the host |
| bus_dout | output | 8 | Byte to the host, zero when not driven |
| bus_doe | output | 1 | Output enable for the bidirectional data pins |
| reg_addr | output | 19 | Register pointer to the bank |
| reg_wdata | output | 16 | Assembled write word |
| reg_we | output | 1 | One-cycle internal write enable |
| reg_rdata | input | 16 | Bank read data for `reg_addr` |

## Verification
The assertions assume that the host keeps every strobe low, and keeps select and data steady, for longer than the synchroniser depth plus one clock. They also assume at least that many idle clocks between cycles, and that a write and a read never end together. The bench drives each phase for four clocks and leaves eight idle clocks between cycles. Inputs change only on the falling clock edge. The host never mixes a read half and a write half within one word.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;

    typedef enum logic {
        DATA_LO = 1'b0,
        DATA_HI = 1'b1
    } data_phase_t;

endpackage

// File: rtl/idx_edge_sync.sv
module idx_edge_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         act_raw,
    input  logic [W-1:0] dat_raw,
    output logic         done,
    output logic [W-1:0] dat_held
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] act_sh;
    logic [W-1:0]      dat_sh [STAGES];
    logic              act_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sh   <= '0;
            act_last <= 1'b0;
            dat_held <= '0;
            for (int i = 0; i < STAGES; i++) dat_sh[i] <= '0;
        end else begin
            act_sh    <= {act_sh[TOP-1:0], act_raw};
            dat_sh[0] <= dat_raw;
            for (int i = 1; i < STAGES; i++) dat_sh[i] <= dat_sh[i-1];
            act_last  <= act_sh[TOP];
            if (act_sh[TOP]) dat_held <= dat_sh[TOP];
        end
    end

    assign done = act_last & ~act_sh[TOP];

endmodule

// File: rtl/idx_addr_ptr.sv
module idx_addr_ptr #(
    parameter int ADDR_W = 19,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr,
    output logic [((ADDR_W+LANE_W-1)/LANE_W > 1 ? $clog2((ADDR_W+LANE_W-1)/LANE_W) : 1)-1:0] cnt
);
    localparam int NB = (ADDR_W + LANE_W - 1) / LANE_W;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;

    logic unused_byte_bits;
    assign unused_byte_bits = ^byte_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= (cnt == CW'(NB - 1)) ? '0 : cnt + 1'b1;
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        localparam int HI = ((LO + LANE_W) < ADDR_W ? (LO + LANE_W) : ADDR_W) - 1;
        localparam int LW = HI - LO + 1;
        logic [LW-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          lane_q <= '0;
            else if (load && cnt == CW'(g))      lane_q <= byte_in[LW-1:0];
        end
        assign addr[HI:LO] = lane_q;
    end

endmodule

// File: rtl/idx_data_fsm.sv
module idx_data_fsm
    import idx_port_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_evt,
    input  logic                wr_evt,
    input  logic                rd_evt,
    input  logic [LANE_W-1:0]   byte_in,
    input  logic [2*LANE_W-1:0] reg_rdata,
    output data_phase_t         phase,
    output logic [2*LANE_W-1:0] reg_wdata,
    output logic                reg_we,
    output logic [2*LANE_W-1:0] rd_hold
);
    data_phase_t       state_q, state_d;
    logic [LANE_W-1:0] lo_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DATA_LO: begin
                if (addr_evt)              state_d = DATA_LO;   // ADDR_CLEAR
                else if (wr_evt || rd_evt) state_d = DATA_HI;   // LO_WRITE / LO_READ
            end
            DATA_HI: begin
                if (addr_evt)              state_d = DATA_LO;   // ADDR_CLEAR
                else if (wr_evt || rd_evt) state_d = DATA_LO;   // HI_DONE
            end
            default:                       state_d = DATA_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DATA_LO;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            rd_hold   <= '0;
        end else begin
            reg_we <= 1'b0;
            if (!addr_evt) begin
                unique case (state_q)
                    DATA_LO: begin
                        if (wr_evt)      lo_q    <= byte_in;
                        else if (rd_evt) rd_hold <= reg_rdata;
                    end
                    DATA_HI: begin
                        if (wr_evt) begin
                            reg_wdata <= {byte_in, lo_q};
                            reg_we    <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign phase = state_q;

endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
    import idx_port_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_cs_n,
    input  logic                bus_wr_n,
    input  logic                bus_rd_n,
    input  logic [LANE_W-1:0]   bus_din,
    output logic [LANE_W-1:0]   bus_dout,
    output logic                bus_doe,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [2*LANE_W-1:0] reg_wdata,
    output logic                reg_we,
    input  logic [2*LANE_W-1:0] reg_rdata
);
    localparam int NB = (ADDR_W + LANE_W - 1) / LANE_W;
    localparam int CW = (NB > 1) ? $clog2(NB) : 1;

    logic              wr_done, rd_done;
    logic [LANE_W:0]   wr_held;
    logic              rd_sel_held;
    logic              wr_sel_held;
    logic              addr_evt, wr_evt, rd_evt;
    logic [CW-1:0]     addr_cnt;
    data_phase_t       phase;
    logic [2*LANE_W-1:0] rd_hold;

    idx_edge_sync #(.STAGES(SYNC_STAGES), .W(LANE_W + 1)) u_wr_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_raw  (~bus_cs_n & ~bus_wr_n),
        .dat_raw  ({bus_sel, bus_din}),
        .done     (wr_done),
        .dat_held (wr_held)
    );

    idx_edge_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_raw  (~bus_cs_n & ~bus_rd_n),
        .dat_raw  (bus_sel),
        .done     (rd_done),
        .dat_held (rd_sel_held)
    );

    assign wr_sel_held = wr_held[LANE_W];
    assign addr_evt    = wr_done & ~wr_sel_held;
    assign wr_evt      = wr_done &  wr_sel_held;
    assign rd_evt      = rd_done &  rd_sel_held & ~wr_done;

    idx_addr_ptr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_evt),
        .byte_in (wr_held[LANE_W-1:0]),
        .addr    (reg_addr),
        .cnt     (addr_cnt)
    );

    idx_data_fsm #(.LANE_W(LANE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_evt  (addr_evt),
        .wr_evt    (wr_evt),
        .rd_evt    (rd_evt),
        .byte_in   (wr_held[LANE_W-1:0]),
        .reg_rdata (reg_rdata),
        .phase     (phase),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .rd_hold   (rd_hold)
    );

    assign bus_doe  = ~bus_cs_n & ~bus_rd_n & bus_sel;
    assign bus_dout = !bus_doe          ? '0 :
                      (phase == DATA_HI) ? rd_hold[2*LANE_W-1:LANE_W]
                                         : reg_rdata[LANE_W-1:0];

endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk
    import idx_port_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANE_W = 8,
    parameter int CW     = 2,
    parameter int NB     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_we,
    input logic                wr_done,
    input logic                wr_sel_held,
    input logic [CW-1:0]       addr_cnt,
    input data_phase_t         phase,
    input logic [2*LANE_W-1:0] rd_hold
);
    // R1: the pointer moves only on the cycle after an address-byte end
    assert_ptr_moves_on_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr) |-> $past(wr_done && !wr_sel_held));

    // R2: the byte-lane counter never leaves its range
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_cnt <= CW'(NB - 1));

    // R3: a write enable is a single cycle
    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3: a write enable follows a data-byte end
    assert_we_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(wr_done && wr_sel_held));

    // R4: an address byte sends the phase back to the low byte
    assert_addr_clears_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !wr_sel_held) |=> phase == DATA_LO);

    // R7: the latched read word is held through the high-byte phase
    assert_read_latch_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == DATA_HI && phase == DATA_HI) |-> $stable(rd_hold));

endmodule

bind idx_reg_port idx_reg_port_chk #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .CW     (CW),
    .NB     (NB)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .wr_done     (wr_done),
    .wr_sel_held (wr_sel_held),
    .addr_cnt    (addr_cnt),
    .phase       (phase),
    .rd_hold     (rd_hold)
);

// File: tb/test_idx_reg_port.sv
module test_idx_reg_port;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [18:0] reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic [15:0] reg_rdata;
    logic [15:0] bank_key = 16'h0000;

    int checks = 0;
    int errors = 0;
    logic [34:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // bench register bank: value depends on the pointer and a changeable key
    assign reg_rdata = reg_addr[15:0] ^ bank_key;

    idx_reg_port i_idx_reg_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_cs_n  (bus_cs_n),
        .bus_wr_n  (bus_wr_n),
        .bus_rd_n  (bus_rd_n),
        .bus_din   (bus_din),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input logic ok, input string req, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // scoreboard monitor: every internal write must match the next expected item
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected write", {reg_addr, reg_wdata}, 35'h0);
            end else begin
                logic [34:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R3 write word", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic bus_write(input logic sel, input logic [7:0] b, input logic cs_first);
        @(negedge clk);
        bus_sel = sel; bus_din = b; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        if (cs_first) begin
            bus_cs_n = 1'b1; @(negedge clk); bus_wr_n = 1'b1;
        end else begin
            bus_wr_n = 1'b1; @(negedge clk); bus_cs_n = 1'b1;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_write(input logic [18:0] a, input logic [15:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic bus_read(input logic sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel = sel; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_doe == sel, req, {34'h0, bus_doe}, {34'h0, sel});
        if (sel) check(bus_dout == exp, req, {27'h0, bus_dout}, {27'h0, exp});
        bus_rd_n = 1'b1; bus_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(reg_addr == 19'h0, "R10 pointer", {16'h0, reg_addr}, 35'h0);
        check(reg_we == 1'b0, "R10 we", {34'h0, reg_we}, 35'h0);
        check(bus_doe == 1'b0, "R10 doe", {34'h0, bus_doe}, 35'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: three address bytes, low to high, top byte keeps [2:0]
        bus_write(1'b0, 8'h34, 1'b0);
        bus_write(1'b0, 8'h12, 1'b0);
        bus_write(1'b0, 8'hFD, 1'b0);
        check(reg_addr == 19'h51234, "R1 pointer", {16'h0, reg_addr}, {16'h0, 19'h51234});

        // R3: low byte then high byte, one write
        bus_write(1'b1, 8'hCD, 1'b0);
        check(exp_q.size() == 0, "R3 no write after low byte", 35'h0, 35'h0);
        expect_write(19'h51234, 16'hABCD);
        bus_write(1'b1, 8'hAB, 1'b0);
        check(exp_q.size() == 0, "R3 write after high byte", {3'h0, 32'(exp_q.size())}, 35'h0);

        // R8: cycles ended by chip select rising first
        bus_write(1'b0, 8'h00, 1'b1);
        bus_write(1'b0, 8'h20, 1'b1);
        bus_write(1'b0, 8'h06, 1'b1);
        check(reg_addr == 19'h62000, "R8 pointer", {16'h0, reg_addr}, {16'h0, 19'h62000});
        expect_write(19'h62000, 16'h2211);
        bus_write(1'b1, 8'h11, 1'b1);
        bus_write(1'b1, 8'h22, 1'b1);
        check(exp_q.size() == 0, "R8 write", {3'h0, 32'(exp_q.size())}, 35'h0);

        // R2: the fourth address byte lands in bits [7:0]
        bus_write(1'b0, 8'h01, 1'b0);
        bus_write(1'b0, 8'h02, 1'b0);
        bus_write(1'b0, 8'h03, 1'b0);
        check(reg_addr == 19'h30201, "R2 pointer", {16'h0, reg_addr}, {16'h0, 19'h30201});
        bus_write(1'b0, 8'h44, 1'b0);
        check(reg_addr == 19'h30244, "R2 wrap", {16'h0, reg_addr}, {16'h0, 19'h30244});
        bus_write(1'b0, 8'h02, 1'b0);
        bus_write(1'b0, 8'h03, 1'b0);

        // R4: a pending low byte is dropped by an address byte
        bus_write(1'b1, 8'h55, 1'b0);
        bus_write(1'b0, 8'h10, 1'b0);
        bus_write(1'b0, 8'h00, 1'b0);
        bus_write(1'b0, 8'h00, 1'b0);
        check(reg_addr == 19'h00010, "R4 pointer", {16'h0, reg_addr}, {16'h0, 19'h10});
        expect_write(19'h00010, 16'h7766);
        bus_write(1'b1, 8'h66, 1'b0);
        bus_write(1'b1, 8'h77, 1'b0);
        check(exp_q.size() == 0, "R4 write", {3'h0, 32'(exp_q.size())}, 35'h0);

        // R9: chip select high between cycles, and a strobe without chip select
        bus_write(1'b0, 8'h78, 1'b0);
        @(negedge clk);
        bus_sel = 1'b0; bus_din = 8'hEE; bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (8) @(negedge clk);
        check(reg_addr == 19'h00078, "R9 ignored strobe", {16'h0, reg_addr}, {16'h0, 19'h78});
        bus_write(1'b0, 8'h56, 1'b0);
        bus_write(1'b0, 8'h01, 1'b0);
        check(reg_addr == 19'h15678, "R9 pointer", {16'h0, reg_addr}, {16'h0, 19'h15678});
        bus_write(1'b1, 8'h9A, 1'b0);
        repeat (20) @(negedge clk);
        expect_write(19'h15678, 16'hBC9A);
        bus_write(1'b1, 8'hBC, 1'b0);
        check(exp_q.size() == 0, "R9 write", {3'h0, 32'(exp_q.size())}, 35'h0);

        // R6: idle bus is not driven
        check(bus_doe == 1'b0, "R6 idle doe", {34'h0, bus_doe}, 35'h0);

        // R6 / R7: low byte live, high byte from the latched word
        bank_key = 16'h0F0F;
        bus_read(1'b1, 8'h77, "R6 low byte");
        bank_key = 16'hFFFF;
        bus_read(1'b1, 8'h59, "R7 high byte latched");
        bus_read(1'b1, 8'h87, "R6 low byte again");

        // R5: inhibited read between the halves changes nothing
        bank_key = 16'h0000;
        bus_read(1'b0, 8'h00, "R5 inhibited no drive");
        check(reg_addr == 19'h15678, "R5 pointer kept", {16'h0, reg_addr}, {16'h0, 19'h15678});
        bus_read(1'b1, 8'hA9, "R5 phase kept");
        bus_read(1'b1, 8'h78, "R5 next low byte");
        bus_read(1'b1, 8'h56, "R7 next high byte");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard empty", {3'h0, 32'(exp_q.size())}, 35'h0);
        finish_run();
    end

endmodule